// File: doc/BRIEF.md
# Video Sync Timing Measurement Unit

This block watches a pair of incoming video sync signals and reports their timing once for every field or frame. A frame runs from one rising edge of vertical sync to the next. Within it, the block counts reference clock cycles to get the horizontal period and the horizontal sync high time, but only on a single line chosen by software. It counts horizontal sync rising edges to get the vertical period and the vertical sync pulse width. Both sync inputs are resynchronised into the clock domain first, and all edges are taken from the resynchronised copies. The uniform resynchronisation delay cancels out of every count.

Each completed frame produces a one-cycle result strobe. The new values are compared with the values from the previous frame. Horizontal and vertical timing each have their own tolerance. A difference larger than the tolerance sets a sticky change flag for that axis, and a masked interrupt follows the flags. A mode detector or an input format tracker uses the block to notice a new input resolution without reading the counters on every frame.

Top module: `sync_meas_unit`

## Requirements
- R1: Lines are numbered from 1, where line 1 begins at the first horizontal sync rising edge after the vertical sync rising edge. When `line_sel` is N, `h_period` reports the number of clock cycles from the rising edge that begins line N to the next horizontal sync rising edge.
- R2: `h_width` reports the number of clock cycles for which horizontal sync is high, counted from the rising edge that begins the selected line.
- R3: `v_period` reports the number of horizontal sync rising edges between two consecutive vertical sync rising edges.
- R4: `v_width` reports the number of horizontal sync rising edges that occur while vertical sync is high.
- R5: `meas_valid` pulses for one cycle at every vertical sync rising edge while `meas_en` is high, except the first such edge after `meas_en` rises, which only starts a measurement. While `meas_en` is low, no result is produced.
- R6: The first result after `meas_en` rises never sets a change flag.
- R7: `h_chg` is set together with a result when either the horizontal period or the horizontal high time differs from the previous result by more than `h_thresh`. A difference equal to `h_thresh` does not set it.
- R8: `v_chg` is set together with a result when either the vertical period or the vertical width differs from the previous result by more than `v_thresh`. A difference equal to `v_thresh` does not set it.
- R9: Both change flags stay set until a cycle with `chg_clr` high clears them.
- R10: `irq` is high exactly when `irq_en` is high and at least one change flag is set.
- R11: All four counts saturate at their all-ones value instead of wrapping.
- R12: If the selected line does not finish before the frame ends (`line_sel` of 0, or at or beyond the last line), `h_period` and `h_width` report 0.
- R13: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_en | input | 1 | Measurement enable |
| hsync_in | input | 1 | Horizontal sync, asynchronous, active high |
| vsync_in | input | 1 | Vertical sync, asynchronous, active high |
| line_sel | input | VCNT_W | Line on which horizontal timing is taken |
| h_thresh | input | HCNT_W | Horizontal change tolerance in clock cycles |
| v_thresh | input | VCNT_W | Vertical change tolerance in lines |
| irq_en | input | 1 | Interrupt mask |
| chg_clr | input | 1 | Clears both change flags |
| h_period | output | HCNT_W | Horizontal period of the selected line |
| h_width | output | HCNT_W | Horizontal sync high time of the selected line |
| v_period | output | VCNT_W | Lines per frame |
| v_width | output | VCNT_W | Vertical sync width in lines |
| meas_valid | output | 1 | One-cycle strobe for a new result |
| h_chg | output | 1 | Sticky horizontal change flag |
| v_chg | output | 1 | Sticky vertical change flag |
| irq | output | 1 | Masked change interrupt |

## Verification
The hardest states to reach are the edges of the comparison and of the counters. One is a frame whose horizontal or vertical difference equals the tolerance exactly. Another is a frame long enough to push every counter into saturation. The bench reaches these with directed frames: identical frames, then a frame whose selected line is stretched by exactly the tolerance, then one stretched by one more cycle. A single line several thousand cycles long is followed by a frame of more than two thousand short lines. Constrained random frames that reuse the previous frame's shape about a third of the time also exercise the no-change path between the directed cases.

// File: rtl/sync_meas_pkg.sv
package sync_meas_pkg;

   // progress of the horizontal measurement within one frame
   typedef enum logic [1:0] {
      HM_IDLE = 2'd0,
      HM_RUN  = 2'd1,
      HM_DONE = 2'd2
   } hmeas_state_e;

endpackage

// File: rtl/sync_edge_det.sv
// Multi-stage resynchroniser followed by rising edge detection.
module sync_edge_det #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic rise
);

   logic [STAGES-1:0] chain;
   logic              lvl_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sync_edge_det: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= 1'b0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= chain[STAGES-1];
   end

   assign lvl  = chain[STAGES-1];
   assign rise = chain[STAGES-1] & ~lvl_q;

endmodule

// File: rtl/vert_counter.sv
// Counts horizontal edges per frame and those seen while vertical sync is high.
module vert_counter #(
   parameter int VCNT_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              hs_rise,
   input  logic              vs_lvl,
   output logic [VCNT_W-1:0] line_cnt,
   output logic [VCNT_W-1:0] vs_lines
);

   localparam logic [VCNT_W-1:0] V_MAX = '1;
   localparam logic [VCNT_W-1:0] V_ONE = VCNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_cnt <= '0;
         vs_lines <= '0;
      end else if (frame_start) begin
         line_cnt <= '0;
         vs_lines <= '0;
      end else if (hs_rise) begin
         if (line_cnt != V_MAX)
            line_cnt <= line_cnt + V_ONE;
         if (vs_lvl && (vs_lines != V_MAX))
            vs_lines <= vs_lines + V_ONE;
      end
   end

endmodule

// File: rtl/horiz_counter.sv
// Measures period and high time of one chosen line of the frame.
module horiz_counter
   import sync_meas_pkg::*;
#(
   parameter int HCNT_W = 12,
   parameter int VCNT_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              hs_rise,
   input  logic              hs_lvl,
   input  logic [VCNT_W-1:0] line_cnt,
   input  logic [VCNT_W-1:0] line_sel,
   output logic [HCNT_W-1:0] per_cnt,
   output logic [HCNT_W-1:0] hi_cnt,
   output logic              done
);

   localparam logic [HCNT_W-1:0] H_MAX = '1;
   localparam logic [HCNT_W-1:0] H_ONE = HCNT_W'(1);

   hmeas_state_e      state;
   logic              hi_open;
   logic [VCNT_W:0]   this_line;
   logic              line_hit;

   // the edge arriving now begins line number line_cnt + 1
   assign this_line = {1'b0, line_cnt} + (VCNT_W+1)'(1);
   assign line_hit  = hs_rise && (this_line == {1'b0, line_sel});
   assign done      = (state == HM_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= HM_IDLE;
         per_cnt <= '0;
         hi_cnt  <= '0;
         hi_open <= 1'b0;
      end else if (frame_start) begin
         state   <= HM_IDLE;
         per_cnt <= '0;
         hi_cnt  <= '0;
         hi_open <= 1'b0;
      end else begin
         unique case (state)
            HM_IDLE: begin
               if (line_hit) begin
                  state   <= HM_RUN;
                  per_cnt <= H_ONE;
                  hi_cnt  <= H_ONE;
                  hi_open <= 1'b1;
               end
            end
            HM_RUN: begin
               if (hs_rise) begin
                  state <= HM_DONE;
               end else begin
                  if (per_cnt != H_MAX)
                     per_cnt <= per_cnt + H_ONE;
                  if (hi_open) begin
                     if (!hs_lvl)
                        hi_open <= 1'b0;
                     else if (hi_cnt != H_MAX)
                        hi_cnt <= hi_cnt + H_ONE;
                  end
               end
            end
            HM_DONE: begin
               state <= HM_DONE;
            end
            default: state <= HM_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/change_cmp.sv
// Absolute difference of two samples compared against a tolerance.
module change_cmp #(
   parameter int W = 12
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] prev,
   input  logic [W-1:0] tol,
   output logic         exceed
);

   logic [W-1:0] delta;

   always_comb begin
      if (cur >= prev) delta = cur - prev;
      else             delta = prev - cur;
      exceed = (delta > tol);
   end

endmodule

// File: rtl/sync_meas_unit.sv
// Per-frame sync timing measurement with format change detection.
module sync_meas_unit
   import sync_meas_pkg::*;
#(
   parameter int HCNT_W        = 12,
   parameter int VCNT_W        = 11,
   parameter int SYNC_STAGES   = 2,
   parameter bit COMPARE_WIDTH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              meas_en,
   input  logic              hsync_in,
   input  logic              vsync_in,
   input  logic [VCNT_W-1:0] line_sel,
   input  logic [HCNT_W-1:0] h_thresh,
   input  logic [VCNT_W-1:0] v_thresh,
   input  logic              irq_en,
   input  logic              chg_clr,
   output logic [HCNT_W-1:0] h_period,
   output logic [HCNT_W-1:0] h_width,
   output logic [VCNT_W-1:0] v_period,
   output logic [VCNT_W-1:0] v_width,
   output logic              meas_valid,
   output logic              h_chg,
   output logic              v_chg,
   output logic              irq
);

   generate
      if (HCNT_W < 4 || HCNT_W > 24) begin : g_bad_h
         $error("sync_meas_unit: HCNT_W out of range");
      end
      if (VCNT_W < 4 || VCNT_W > 16) begin : g_bad_v
         $error("sync_meas_unit: VCNT_W out of range");
      end
      if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_s
         $error("sync_meas_unit: SYNC_STAGES out of range");
      end
   endgenerate

   // synchronised sync inputs
   logic hs_lvl, hs_rise, vs_lvl, vs_rise;

   sync_edge_det #(.STAGES(SYNC_STAGES)) i_hs_sync (
      .clk(clk), .rst_n(rst_n), .din(hsync_in), .lvl(hs_lvl), .rise(hs_rise)
   );
   sync_edge_det #(.STAGES(SYNC_STAGES)) i_vs_sync (
      .clk(clk), .rst_n(rst_n), .din(vsync_in), .lvl(vs_lvl), .rise(vs_rise)
   );

   // frame counters
   logic [VCNT_W-1:0] line_cnt, vs_lines;
   logic [HCNT_W-1:0] per_cnt, hi_cnt;
   logic              h_done;

   vert_counter #(.VCNT_W(VCNT_W)) i_vert (
      .clk(clk), .rst_n(rst_n), .frame_start(vs_rise), .hs_rise(hs_rise),
      .vs_lvl(vs_lvl), .line_cnt(line_cnt), .vs_lines(vs_lines)
   );

   horiz_counter #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) i_horiz (
      .clk(clk), .rst_n(rst_n), .frame_start(vs_rise), .hs_rise(hs_rise),
      .hs_lvl(hs_lvl), .line_cnt(line_cnt), .line_sel(line_sel),
      .per_cnt(per_cnt), .hi_cnt(hi_cnt), .done(h_done)
   );

   // frame sequencing
   logic running, have_prev, finish;
   logic [HCNT_W-1:0] cur_hp, cur_hw;

   assign finish = meas_en && vs_rise && running;
   assign cur_hp = h_done ? per_cnt : '0;
   assign cur_hw = h_done ? hi_cnt  : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        running <= 1'b0;
      else if (!meas_en) running <= 1'b0;
      else if (vs_rise)  running <= 1'b1;
   end

   // comparison against the previous result
   logic hp_ex, hw_ex, vp_ex, vw_ex;
   logic h_exceed, v_exceed;

   change_cmp #(.W(HCNT_W)) i_cmp_hp (
      .cur(cur_hp), .prev(h_period), .tol(h_thresh), .exceed(hp_ex)
   );
   change_cmp #(.W(VCNT_W)) i_cmp_vp (
      .cur(line_cnt), .prev(v_period), .tol(v_thresh), .exceed(vp_ex)
   );

   generate
      if (COMPARE_WIDTH) begin : g_cmp_width
         change_cmp #(.W(HCNT_W)) i_cmp_hw (
            .cur(cur_hw), .prev(h_width), .tol(h_thresh), .exceed(hw_ex)
         );
         change_cmp #(.W(VCNT_W)) i_cmp_vw (
            .cur(vs_lines), .prev(v_width), .tol(v_thresh), .exceed(vw_ex)
         );
         assign h_exceed = hp_ex | hw_ex;
         assign v_exceed = vp_ex | vw_ex;
      end else begin : g_cmp_period
         assign hw_ex    = 1'b0;
         assign vw_ex    = 1'b0;
         assign h_exceed = hp_ex;
         assign v_exceed = vp_ex;
      end
   endgenerate

   // result registers double as the previous capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_period   <= '0;
         h_width    <= '0;
         v_period   <= '0;
         v_width    <= '0;
         meas_valid <= 1'b0;
         have_prev  <= 1'b0;
      end else begin
         meas_valid <= finish;
         if (finish) begin
            h_period  <= cur_hp;
            h_width   <= cur_hw;
            v_period  <= line_cnt;
            v_width   <= vs_lines;
            have_prev <= 1'b1;
         end else if (!meas_en) begin
            have_prev <= 1'b0;
         end
      end
   end

   // sticky flags, a new detection wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_chg <= 1'b0;
         v_chg <= 1'b0;
      end else begin
         h_chg <= (h_chg & ~chg_clr) | (finish & have_prev & h_exceed);
         v_chg <= (v_chg & ~chg_clr) | (finish & have_prev & v_exceed);
      end
   end

   assign irq = irq_en & (h_chg | v_chg);

endmodule

// File: rtl/sync_meas_checker.sv
module sync_meas_checker #(
   parameter int HCNT_W = 12,
   parameter int VCNT_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              meas_en,
   input logic              chg_clr,
   input logic              irq_en,
   input logic              meas_valid,
   input logic [HCNT_W-1:0] h_period,
   input logic [HCNT_W-1:0] h_width,
   input logic [VCNT_W-1:0] v_period,
   input logic [VCNT_W-1:0] v_width,
   input logic              h_chg,
   input logic              v_chg,
   input logic              irq
);

   assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |=> !meas_valid);

   assert_valid_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !meas_en |=> !meas_valid);

   assert_hold_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(h_period) |-> meas_valid);

   assert_hold_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(v_period) |-> meas_valid);

   assert_width_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |-> (h_width <= h_period));

   assert_vwidth_in_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |-> (v_width <= v_period));

   assert_h_set_with_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(h_chg) |-> meas_valid);

   assert_v_set_with_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(v_chg) |-> meas_valid);

   assert_h_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (h_chg && !chg_clr) |=> h_chg);

   assert_v_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (v_chg && !chg_clr) |=> v_chg);

   assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);

endmodule

bind sync_meas_unit sync_meas_checker #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) i_sync_meas_checker (
   .clk(clk), .rst_n(rst_n), .meas_en(meas_en), .chg_clr(chg_clr), .irq_en(irq_en),
   .meas_valid(meas_valid), .h_period(h_period), .h_width(h_width),
   .v_period(v_period), .v_width(v_width), .h_chg(h_chg), .v_chg(v_chg), .irq(irq)
);

// File: tb/test_sync_meas_unit.sv
module test_sync_meas_unit;

   localparam int CLK_PERIOD = 10;
   localparam int HW = 12;
   localparam int VW = 11;
   localparam int HMAX = (1 << HW) - 1;
   localparam int VMAX = (1 << VW) - 1;

   logic clk = 1'b0, rst_n = 1'b0, meas_en = 1'b0, hsync_in = 1'b0, vsync_in = 1'b0;
   logic irq_en = 1'b0, chg_clr = 1'b0;
   logic [VW-1:0] line_sel = VW'(1);
   logic [HW-1:0] h_thresh = '0;
   logic [VW-1:0] v_thresh = '0;
   logic [HW-1:0] h_period, h_width;
   logic [VW-1:0] v_period, v_width;
   logic meas_valid, h_chg, v_chg, irq;

   int errors = 0, checks = 0;
   int exp_hp[256], exp_hw[256], exp_vp[256], exp_vw[256];
   int wr_idx = 0, rd_idx = 0, n_valid = 0;
   bit m_have = 0, m_hchg = 0, m_vchg = 0;
   int p_hp = 0, p_hw = 0, p_vp = 0, p_vw = 0;

   sync_meas_unit #(.HCNT_W(HW), .VCNT_W(VW)) i_sync_meas_unit (
      .clk(clk), .rst_n(rst_n), .meas_en(meas_en), .hsync_in(hsync_in),
      .vsync_in(vsync_in), .line_sel(line_sel), .h_thresh(h_thresh),
      .v_thresh(v_thresh), .irq_en(irq_en), .chg_clr(chg_clr),
      .h_period(h_period), .h_width(h_width), .v_period(v_period),
      .v_width(v_width), .meas_valid(meas_valid), .h_chg(h_chg),
      .v_chg(v_chg), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int sat(input int x, input int mx);
      return (x > mx) ? mx : x;
   endfunction

   function automatic int adiff(input int a, input int b);
      return (a > b) ? a - b : b - a;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   // reference model of results and flags, evaluated on each strobe
   always @(negedge clk) begin
      if (rst_n) begin
         if (chg_clr) begin
            m_hchg = 0;
            m_vchg = 0;
         end
         if (!meas_en) m_have = 0;
         if (meas_valid) begin
            n_valid++;
            if (rd_idx == wr_idx) begin
               check("R5 unexpected strobe", 1, 0);
            end else begin
               int e_hp, e_hw, e_vp, e_vw;
               e_hp = exp_hp[rd_idx % 256];
               e_hw = exp_hw[rd_idx % 256];
               e_vp = exp_vp[rd_idx % 256];
               e_vw = exp_vw[rd_idx % 256];
               rd_idx++;
               check("R1 h_period", int'(h_period), e_hp);
               check("R2 h_width", int'(h_width), e_hw);
               check("R3 v_period", int'(v_period), e_vp);
               check("R4 v_width", int'(v_width), e_vw);
               if (m_have) begin
                  if (adiff(e_hp, p_hp) > int'(h_thresh) || adiff(e_hw, p_hw) > int'(h_thresh))
                     m_hchg = 1;
                  if (adiff(e_vp, p_vp) > int'(v_thresh) || adiff(e_vw, p_vw) > int'(v_thresh))
                     m_vchg = 1;
               end
               m_have = 1;
               p_hp = e_hp; p_hw = e_hw; p_vp = e_vp; p_vw = e_vw;
               check("R7 h_chg", int'(h_chg), int'(m_hchg));
               check("R8 v_chg", int'(v_chg), int'(m_vchg));
               check("R10 irq", int'(irq), int'(irq_en && (m_hchg || m_vchg)));
            end
         end
      end
   end

   // one frame: vsync rise, two idle cycles, then L lines
   task automatic frame(input int L, input int len, input int hw, input int vwl,
                        input int sel, input int extra, input bit clr);
      line_sel = VW'(sel);
      vsync_in = 1'b1;
      hsync_in = 1'b0;
      tick(2);
      for (int l = 1; l <= L; l++) begin
         int ll;
         ll = len + ((l == sel) ? extra : 0);
         for (int c = 0; c < ll; c++) begin
            hsync_in = (c < hw);
            if (c == ll - 1 && l == vwl) vsync_in = 1'b0;
            chg_clr = (clr && l == 2 && c == 0);
            tick(1);
            if (clr && l == 2 && c == 0) begin
               chg_clr = 1'b0;
               check("R9 h_chg cleared", int'(h_chg), 0);
               check("R9 v_chg cleared", int'(v_chg), 0);
               check("R10 irq after clear", int'(irq), 0);
            end
         end
      end
      hsync_in = 1'b0;
      if (meas_en) begin
         exp_hp[wr_idx % 256] = (sel >= 1 && sel < L) ? sat(len + extra, HMAX) : 0;
         exp_hw[wr_idx % 256] = (sel >= 1 && sel < L) ? sat(hw, HMAX) : 0;
         exp_vp[wr_idx % 256] = sat(L, VMAX);
         exp_vw[wr_idx % 256] = sat(vwl, VMAX);
         wr_idx++;
      end
   endtask

   // closing vsync edge that completes the last frame
   task automatic close_frame();
      vsync_in = 1'b1;
      tick(3);
      vsync_in = 1'b0;
      tick(8);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int L, len, hw, vwl, sel, n0;
      void'($urandom(32'd5113));
      tick(3);
      rst_n = 1'b1;
      tick(2);
      // R13 reset state
      check("R13 h_period", int'(h_period), 0);
      check("R13 h_width", int'(h_width), 0);
      check("R13 v_period", int'(v_period), 0);
      check("R13 v_width", int'(v_width), 0);
      check("R13 meas_valid", int'(meas_valid), 0);
      check("R13 flags", int'(h_chg | v_chg | irq), 0);

      // directed thresholds and stickiness
      meas_en = 1'b1; irq_en = 1'b1;
      h_thresh = HW'(2); v_thresh = VW'(1);
      frame(8, 20, 5, 2, 3, 0, 0);     // first result, R6
      frame(8, 20, 5, 2, 3, 0, 0);
      frame(8, 20, 5, 2, 3, 2, 0);     // delta equals tolerance, R7
      frame(8, 20, 5, 2, 3, 5, 0);     // delta 3, sets h flag
      frame(9, 20, 5, 2, 3, 5, 1);     // clear mid frame, R9; vertical delta 1
      frame(11, 20, 5, 2, 3, 5, 0);    // vertical delta 2, R8
      frame(8, 20, 5, 2, 12, 0, 0);    // selected line absent, R12
      frame(8, 20, 5, 2, 8, 0, 0);     // selected line is the last one, R12
      irq_en = 1'b0;
      tick(1);
      check("R10 masked irq", int'(irq), 0);
      irq_en = 1'b1;
      tick(1);
      check("R10 unmasked irq", int'(irq), int'(m_hchg || m_vchg));
      close_frame();

      // disabled: no results, R5
      meas_en = 1'b0;
      tick(2);
      n0 = n_valid;
      frame(6, 16, 4, 2, 2, 0, 0);
      frame(6, 16, 4, 2, 2, 0, 0);
      close_frame();
      check("R5 no strobe while disabled", n_valid, n0);

      // re-enable with a very different format: first result must not flag, R6
      chg_clr = 1'b1; tick(1); chg_clr = 1'b0;
      meas_en = 1'b1;
      frame(5, 40, 10, 3, 2, 0, 0);
      frame(5, 40, 10, 3, 2, 0, 0);
      close_frame();
      check("R6 first result after enable", int'(h_chg | v_chg), 0);
      meas_en = 1'b0; tick(2); meas_en = 1'b1;

      // constrained random frames
      L = 8; len = 20; hw = 4; vwl = 2; sel = 3;
      for (int i = 0; i < 25; i++) begin
         if ($urandom % 3 != 0) begin
            L   = 4 + int'($urandom % 9);
            len = 8 + int'($urandom % 33);
            hw  = 1 + int'($urandom % (len - 2));
            vwl = 1 + int'($urandom % (L - 1));
            sel = int'($urandom % (L + 2));
         end
         h_thresh = HW'($urandom % 6);
         v_thresh = VW'($urandom % 3);
         irq_en   = 1'($urandom % 2);
         frame(L, len, hw, vwl, sel, int'($urandom % 4), ($urandom % 5) == 0);
      end
      close_frame();
      meas_en = 1'b0; tick(2); meas_en = 1'b1;

      // saturation, R11
      h_thresh = '0; v_thresh = '0;
      frame(3, 5000, 4500, 1, 1, 0, 0);
      frame(2100, 4, 1, 2100, 5, 0, 0);
      close_frame();
      check("R11 strobes consumed", rd_idx, wr_idx);

      tick(5);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule